// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block sits between the instruction decoder of a serial flash device and its 16-bit status register. It receives single-cycle strobes for write enable, write status, suspend and resume, together with the data of a status write. It also receives the level of the active-low write-protect pin and a single-cycle power-cycle event. It keeps the two protection-mode bits, the quad-enable bit, the write-enable latch and the suspend flag. For every status write it decides whether the write is taken, using the protection mode, the pin level, the quad-enable bit and the latch. Each write attempt, taken or not, drops the latch. A refused write raises a one-cycle `write_rejected_o` pulse.

The protection mode is held in a four-state machine whose encoding is also the value of status bits 8:7. The states are `MODE_SOFT` (00), `MODE_PIN` (01), `MODE_POWER` (10) and `MODE_OTP` (11). An accepted write moves the machine from `MODE_SOFT` or `MODE_PIN` to the mode carried in the written data. A power-cycle event moves it from `MODE_POWER` back to `MODE_SOFT`. `MODE_OTP` has no exit.

Two small machines hold the other flags. The write-enable latch moves between `WEL_CLEAR` and `WEL_SET`: the write-enable strobe sets it, and a status write or a power cycle clears it. The suspend flag moves between `SUS_IDLE` and `SUS_HELD`: the suspend strobe sets it, and resume or a power cycle clears it. The `io_quad_o` output tells the pad logic whether the protect and hold pins serve as data lines IO2/IO3.

Top module: `sr_guard`

## Requirements
- R1: After `rst_n` is released, `status_o` is 0x0000, and `wel_o`, `io_quad_o` and `write_rejected_o` are 0.
- R2: A write-enable strobe sets the latch, which is visible on `wel_o` and on status bit 1 from the next cycle. A write-status strobe or a power cycle clears the latch at that edge, whether or not the write is taken.
- R3: In mode 00 (bits 8:7), a status write is taken exactly when the latch is 1, at any pin level.
- R4: In mode 01 with quad enable 0, a low protect pin refuses every status write. A high pin lets a write through when the latch is 1.
- R5: In mode 10 every status write is refused. A power cycle returns bits 8:7 to 00.
- R6: In mode 11 every status write is refused at any pin level, and power cycles leave bits 8:7 at 11.
- R7: A taken write stores every data bit except bit 1 (latch) and bit 15 (suspend), and the new value shows on `status_o` in the next cycle. A refused write leaves those bits unchanged and makes `write_rejected_o` 1 for exactly the next cycle.
- R8: The suspend strobe sets status bit 15. The resume strobe or a power cycle clears it. A status write never changes it.
- R9: `io_quad_o` follows status bit 9. While bit 9 is 1, the protect pin counts as high for the mode-01 decision.
- R10: A power cycle keeps the quad-enable bit, the plain storage bits, and any mode other than 10.
- R11: Strobes in the same cycle are resolved by priority. A power cycle overrides every other strobe. A write-status strobe uses the latch value from before that cycle and discards a write-enable strobe in the same cycle. Resume overrides suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset to the as-shipped state |
| wren_i | input | 1 | Write-enable instruction strobe |
| wrsr_i | input | 1 | Write-status instruction strobe |
| wr_data_i | input | 16 | New status value for a write-status strobe |
| susp_i | input | 1 | Suspend instruction strobe |
| resume_i | input | 1 | Resume instruction strobe |
| wp_n_i | input | 1 | Write-protect pin level, active low |
| pwr_cycle_i | input | 1 | Single-cycle power-down/power-up event |
| status_o | output | 16 | Current status value |
| wel_o | output | 1 | Write-enable latch |
| io_quad_o | output | 1 | 1: protect/hold pins act as IO2/IO3 |
| write_rejected_o | output | 1 | One-cycle pulse after a refused status write |

## Verification
The hardest situation to reach from the ports is the mode-01 write with quad enable set and the pin held low. To get there, two accepted writes must first be landed in the right order: one that selects the pin-controlled mode with the pin high, and one that sets quad enable. Only after that can the pin be dropped. A second hard case is the one-way lock in mode 11, which random stimulus would otherwise reach early and stay in for the rest of the run. Directed sequences build both chains explicitly. In the random phase, data values that select mode 11 are rare, the pin-controlled mode is favoured, and a reset is applied periodically so that every mode is visited many times.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    typedef enum logic [1:0] {
        MODE_SOFT  = 2'b00,
        MODE_PIN   = 2'b01,
        MODE_POWER = 2'b10,
        MODE_OTP   = 2'b11
    } prot_mode_e;

    typedef enum logic {
        WEL_CLEAR = 1'b0,
        WEL_SET   = 1'b1
    } wel_state_e;

    typedef enum logic {
        SUS_IDLE = 1'b0,
        SUS_HELD = 1'b1
    } sus_state_e;

    typedef struct packed {
        logic pwr;
        logic wrsr;
        logic wren;
        logic susp;
        logic resume;
    } strobes_t;

endpackage

// File: rtl/sr_guard_policy.sv
module sr_guard_policy
    import sr_guard_pkg::*;
(
    input  prot_mode_e mode_i,
    input  logic       wel_i,
    input  logic       wp_n_i,
    input  logic       quad_i,
    output logic       allow_o
);

    logic pin_high;

    always_comb begin
        pin_high = wp_n_i | quad_i;
        allow_o  = 1'b0;
        unique case (mode_i)
            MODE_SOFT:  allow_o = wel_i;
            MODE_PIN:   allow_o = wel_i & pin_high;
            MODE_POWER: allow_o = 1'b0;
            MODE_OTP:   allow_o = 1'b0;
            default:    allow_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sr_guard_mode_fsm.sv
module sr_guard_mode_fsm
    import sr_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_i,
    input  logic       accept_i,
    input  prot_mode_e new_mode_i,
    output prot_mode_e mode_o
);

    prot_mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_SOFT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SOFT:  if (accept_i) state_d = new_mode_i;
            MODE_PIN:   if (accept_i) state_d = new_mode_i;
            MODE_POWER: if (pwr_i)    state_d = MODE_SOFT;
            MODE_OTP:   state_d = MODE_OTP;
            default:    state_d = MODE_SOFT;
        endcase
    end

    assign mode_o = state_q;

    p_otp_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == MODE_OTP |=> state_q == MODE_OTP);

    p_power_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_POWER && pwr_i) |=> state_q == MODE_SOFT);

    p_power_keeps_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MODE_POWER && pwr_i) |=> state_q == $past(state_q));

endmodule

// File: rtl/sr_guard_wel_fsm.sv
module sr_guard_wel_fsm
    import sr_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);

    wel_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WEL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WEL_CLEAR: if (set_i && !clr_i) state_d = WEL_SET;
            WEL_SET:   if (clr_i)           state_d = WEL_CLEAR;
            default:   state_d = WEL_CLEAR;
        endcase
    end

    assign wel_o = (state_q == WEL_SET);

    p_wel_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> state_q == WEL_CLEAR);

    p_wel_raised_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> state_q == WEL_SET);

endmodule

// File: rtl/sr_guard_sus_fsm.sv
module sr_guard_sus_fsm
    import sr_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic sus_o
);

    sus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUS_IDLE: if (set_i && !clr_i) state_d = SUS_HELD;
            SUS_HELD: if (clr_i)           state_d = SUS_IDLE;
            default:  state_d = SUS_IDLE;
        endcase
    end

    assign sus_o = (state_q == SUS_HELD);

    p_sus_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> state_q == SUS_IDLE);

    p_sus_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUS_HELD && !clr_i) |=> state_q == SUS_HELD);

endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int WEL_POS  = 1,
    parameter int SRP0_POS = 7,
    parameter int SRP1_POS = 8,
    parameter int QE_POS   = 9,
    parameter int SUS_POS  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wren_i,
    input  logic             wrsr_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             susp_i,
    input  logic             resume_i,
    input  logic             wp_n_i,
    input  logic             pwr_cycle_i,
    output logic [WIDTH-1:0] status_o,
    output logic             wel_o,
    output logic             io_quad_o,
    output logic             write_rejected_o
);

    localparam logic [WIDTH-1:0] ONE        = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] SPECIAL    = (ONE << WEL_POS) | (ONE << SUS_POS)
                                            | (ONE << SRP0_POS) | (ONE << SRP1_POS);
    localparam logic [WIDTH-1:0] STORE_MASK = ~SPECIAL;
    localparam logic [WIDTH-1:0] KEEP_MASK  = ~((ONE << WEL_POS) | (ONE << SUS_POS));

    strobes_t         go;
    prot_mode_e       mode;
    prot_mode_e       new_mode;
    logic             wel;
    logic             sus;
    logic             allow;
    logic             accept;
    logic [WIDTH-1:0] store_q;
    logic             rejected_q;

    // Priority resolution of same-cycle strobes
    always_comb begin
        go.pwr    = pwr_cycle_i;
        go.wrsr   = wrsr_i & ~pwr_cycle_i;
        go.wren   = wren_i & ~wrsr_i & ~pwr_cycle_i;
        go.resume = resume_i & ~pwr_cycle_i;
        go.susp   = susp_i & ~resume_i & ~pwr_cycle_i;
    end

    assign new_mode = prot_mode_e'({wr_data_i[SRP1_POS], wr_data_i[SRP0_POS]});
    assign accept   = go.wrsr & allow;

    sr_guard_policy u_policy (
        .mode_i  (mode),
        .wel_i   (wel),
        .wp_n_i  (wp_n_i),
        .quad_i  (store_q[QE_POS]),
        .allow_o (allow)
    );

    sr_guard_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_i      (go.pwr),
        .accept_i   (accept),
        .new_mode_i (new_mode),
        .mode_o     (mode)
    );

    sr_guard_wel_fsm u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (go.wren),
        .clr_i (go.wrsr | go.pwr),
        .wel_o (wel)
    );

    sr_guard_sus_fsm u_sus (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (go.susp),
        .clr_i (go.resume | go.pwr),
        .sus_o (sus)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q    <= '0;
            rejected_q <= 1'b0;
        end else begin
            rejected_q <= go.wrsr & ~allow;
            if (accept) store_q <= wr_data_i & STORE_MASK;
        end
    end

    always_comb begin
        status_o           = store_q;
        status_o[SRP0_POS] = mode[0];
        status_o[SRP1_POS] = mode[1];
        status_o[WEL_POS]  = wel;
        status_o[SUS_POS]  = sus;
    end

    assign wel_o            = wel;
    assign io_quad_o        = store_q[QE_POS];
    assign write_rejected_o = rejected_q;

    p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        write_rejected_o |-> (status_o & KEEP_MASK) == ($past(status_o) & KEEP_MASK));

    p_power_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_POWER && wrsr_i && !pwr_cycle_i) |=> write_rejected_o);

    p_otp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OTP && wrsr_i && !pwr_cycle_i) |=> write_rejected_o);

    p_quad_overrides_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PIN && io_quad_o && wel_o && wrsr_i && !pwr_cycle_i)
        |=> !write_rejected_o);

    p_write_keeps_sus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_i && !susp_i && !resume_i && !pwr_cycle_i)
        |=> status_o[SUS_POS] == $past(status_o[SUS_POS]));

endmodule

// File: tb/test_sr_guard.sv
module test_sr_guard;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] STORE_MASK = 16'h7E7D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wren_i = 1'b0, wrsr_i = 1'b0, susp_i = 1'b0, resume_i = 1'b0;
    logic        wp_n_i = 1'b1, pwr_cycle_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] status_o;
    logic        wel_o, io_quad_o, write_rejected_o;

    int n_checks = 0;
    int n_fails  = 0;

    logic [15:0] m_store;
    logic [1:0]  m_mode;
    logic        m_wel, m_sus, m_rej;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_guard i_sr_guard (
        .clk              (clk),
        .rst_n            (rst_n),
        .wren_i           (wren_i),
        .wrsr_i           (wrsr_i),
        .wr_data_i        (wr_data_i),
        .susp_i           (susp_i),
        .resume_i         (resume_i),
        .wp_n_i           (wp_n_i),
        .pwr_cycle_i      (pwr_cycle_i),
        .status_o         (status_o),
        .wel_o            (wel_o),
        .io_quad_o        (io_quad_o),
        .write_rejected_o (write_rejected_o)
    );

    function automatic logic [15:0] exp_status();
        logic [15:0] v;
        v = m_store;
        v[8] = m_mode[1];
        v[7] = m_mode[0];
        v[1] = m_wel;
        v[15] = m_sus;
        return v;
    endfunction

    function automatic logic allow_f(logic [1:0] mode, logic wel, logic wp_n, logic quad);
        case (mode)
            2'b00:   return wel;
            2'b01:   return wel & (wp_n | quad);
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_store = '0; m_mode = 2'b00; m_wel = 1'b0; m_sus = 1'b0; m_rej = 1'b0;
    endtask

    task automatic model_step(output string tag);
        tag = "R7";
        if (pwr_cycle_i) begin
            tag = (m_mode == 2'b10) ? "R5" : "R10";
            if (m_mode == 2'b10) m_mode = 2'b00;
            m_wel = 1'b0; m_sus = 1'b0; m_rej = 1'b0;
        end else begin
            if (wrsr_i) begin
                case (m_mode)
                    2'b00: tag = "R3";
                    2'b01: tag = m_store[9] ? "R9" : "R4";
                    2'b10: tag = "R5";
                    default: tag = "R6";
                endcase
                if (wren_i) tag = "R11";
                m_rej = !allow_f(m_mode, m_wel, wp_n_i, m_store[9]);
                if (!m_rej) begin
                    m_store = wr_data_i & STORE_MASK;
                    m_mode  = {wr_data_i[8], wr_data_i[7]};
                end
                m_wel = 1'b0;
            end else begin
                m_rej = 1'b0;
                if (wren_i) m_wel = 1'b1;
            end
            if (resume_i) m_sus = 1'b0;
            else if (susp_i) m_sus = 1'b1;
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge
    task automatic step(input logic wren, input logic wrsr, input logic [15:0] d,
                        input logic susp, input logic resume, input logic wp_n, input logic pwr);
        string tag;
        wren_i = wren; wrsr_i = wrsr; wr_data_i = d;
        susp_i = susp; resume_i = resume; wp_n_i = wp_n; pwr_cycle_i = pwr;
        @(posedge clk);
        @(negedge clk);
        model_step(tag);
        wren_i = 1'b0; wrsr_i = 1'b0; susp_i = 1'b0; resume_i = 1'b0; pwr_cycle_i = 1'b0;
        check(status_o == exp_status(), tag, status_o, exp_status());
        check(wel_o == m_wel, "R2", {15'b0, wel_o}, {15'b0, m_wel});
        check(write_rejected_o == m_rej, tag, {15'b0, write_rejected_o}, {15'b0, m_rej});
        check(io_quad_o == m_store[9], "R9", {15'b0, io_quad_o}, {15'b0, m_store[9]});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check(status_o == 16'h0000, "R1", status_o, 16'h0000);
        check({wel_o, io_quad_o, write_rejected_o} == 3'b000, "R1",
              {13'b0, wel_o, io_quad_o, write_rejected_o}, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        do_reset();

        // R3: no latch -> refused; latch with pin low -> taken
        step(0, 1, 16'h0200, 0, 0, 0, 0);
        check(write_rejected_o == 1'b1, "R3", {15'b0, write_rejected_o}, 16'h0001);
        step(1, 0, 16'h0000, 0, 0, 0, 0);
        step(0, 1, 16'h0004, 0, 0, 0, 0);
        check(status_o == 16'h0004, "R3", status_o, 16'h0004);

        // R4: mode 01, pin low refuses, pin high takes
        step(1, 0, 0, 0, 0, 1, 0);
        step(0, 1, 16'h0080, 0, 0, 1, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 1, 16'h0280, 0, 0, 0, 0);
        check(status_o == 16'h0080, "R4", status_o, 16'h0080);
        step(1, 0, 0, 0, 0, 1, 0);
        step(0, 1, 16'h0280, 0, 0, 1, 0);

        // R9: quad on, low pin no longer blocks
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 1, 16'h0290, 0, 0, 0, 0);
        check(status_o == 16'h0290 && io_quad_o, "R9", status_o, 16'h0290);

        // R5: mode 10 refuses, power cycle unlocks, quad kept (R10)
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 1, 16'h0300, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 1, 0);
        step(0, 1, 16'h0000, 0, 0, 1, 0);
        check(write_rejected_o == 1'b1, "R5", {15'b0, write_rejected_o}, 16'h0001);
        step(0, 0, 0, 1, 0, 1, 0);
        step(1, 0, 0, 0, 0, 1, 1);
        check(status_o == 16'h0200, "R10", status_o, 16'h0200);

        // R8: suspend survives a write that carries bit 15 = 0; resume beats suspend
        step(0, 0, 0, 1, 0, 1, 0);
        step(1, 0, 0, 0, 0, 1, 0);
        step(0, 1, 16'h0000, 0, 0, 1, 0);
        check(status_o == 16'h8000, "R8", status_o, 16'h8000);
        step(0, 0, 0, 1, 1, 1, 0);
        check(status_o[15] == 1'b0, "R11", status_o, 16'h0000);

        // R11: write enable with write status in the same cycle is discarded
        step(1, 1, 16'h0001, 0, 0, 1, 0);
        check({wel_o, write_rejected_o} == 2'b01, "R11", {14'b0, wel_o, write_rejected_o}, 16'h0001);
        step(1, 0, 0, 1, 0, 1, 1);
        check(wel_o == 1'b0 && status_o[15] == 1'b0, "R11", status_o, 16'h0000);

        // R6: mode 11 holds through power cycles
        step(1, 0, 0, 0, 0, 1, 0);
        step(0, 1, 16'h0180, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 1, 1);
        check(status_o[8:7] == 2'b11, "R6", status_o, 16'h0180);
        step(1, 0, 0, 0, 0, 1, 0);
        step(0, 1, 16'h0000, 0, 0, 1, 0);
        check(write_rejected_o == 1'b1, "R6", {15'b0, write_rejected_o}, 16'h0001);

        // Random phase
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            logic [15:0] d;
            if (i % 500 == 499) do_reset();
            d = 16'($urandom);
            if ((d[8:7] == 2'b11) && ($urandom % 8 != 0)) d[8:7] = 2'b01;
            step(($urandom % 3) == 0, ($urandom % 4) == 0, d,
                 ($urandom % 8) == 0, ($urandom % 8) == 0,
                 1'($urandom), ($urandom % 40) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule